// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level translation structure held in memory. A request carries the linear address, whether the access is a write, whether it comes from supervisor level, the paging-enable and write-protect controls, and the base of the top-level table. The walker fetches one 32-bit directory entry, then one 32-bit table entry, over a simple request/valid read port. It then either reports the finished physical address or raises a fault together with a cause code.

When paging is off, the walker passes the linear address straight through and makes no memory read. A new request is taken only while the walker is idle. Each result is reported by a one-cycle pulse on `done` or on `fault`.

Top module: `ptw_walker`

## Requirements
- R1: With `pg_enable` low at acceptance, `done` pulses in the first cycle after the accepting edge, `phys_addr` equals the linear address, and `mem_req` never rises for that request.
- R2: The first read of a paged walk is at `{dir_base[31:12], lin[31:22], 2'b00}`.
- R3: The second read is at `{E1[31:12], lin[21:12], 2'b00}`, where E1 is the returned directory entry.
- R4: A walk that succeeds ends with `done` high and `phys_addr = {E2[31:12], lin[11:0]}`, where E2 is the returned table entry.
- R5: Entry bit 0 is the present flag. If it is clear in either entry, `fault` pulses with `fault_cause` = 1. A missing directory entry ends the walk after exactly one read.
- R6: Entry bit 2 grants user access, and the grant is the AND of both entries. A user access (`req_super` low) without the grant faults with cause 2.
- R7: Entry bit 1 grants writes, and the grant is the AND of both entries. A user write without the grant faults with cause 3.
- R8: A supervisor write to a page without the write grant faults with cause 3 when `wp_enable` is high, and completes normally when `wp_enable` is low.
- R9: When several fault conditions hold at once, the cause is chosen in the order not-present (1), then privilege (2), then write (3).
- R10: `done` and `fault` are single-cycle pulses and are never high together. While `mem_req` waits for `mem_rvalid`, `mem_addr` is held stable.
- R11: A `req_valid` pulse during a walk in progress is ignored. The running walk completes with its own captured inputs.
- R12: After reset, `done`, `fault` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start strobe, taken only when idle |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_super | input | 1 | 1 = supervisor access, 0 = user |
| pg_enable | input | 1 | Paging enable; 0 bypasses translation |
| wp_enable | input | 1 | Make read-only pages binding on supervisor writes |
| dir_base | input | 32 | Base of the directory (bits 31:12 used) |
| mem_req | output | 1 | Read request, held until answered |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry returned by memory |
| done | output | 1 | One-cycle pulse: translation complete |
| phys_addr | output | 32 | Translated address, valid with `done` |
| fault | output | 1 | One-cycle pulse: walk aborted |
| fault_cause | output | 2 | 1 not present, 2 privilege, 3 write; valid with `fault` |

## Verification
The bench varies the read latency at random and mixes present, privilege and write bits at both levels, so that a walker which checked only one level, or used OR instead of AND, returns the wrong cause. Directed cases target the write-protect split for supervisor writes, where a swapped rule lets a protected write through or blocks a legal one. They also cover overlapping fault conditions, where a wrong priority order shows the wrong cause, and a directory miss, where a walker that carries on issues a second read. A request strobe in the middle of a walk and bypass requests check for re-capture mid-walk and for spurious memory traffic when paging is off.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
    // bit positions of the permission fields inside every entry
    localparam int ATTR_W = 3;
    localparam int P_BIT  = 0;
    localparam int RW_BIT = 1;
    localparam int US_BIT = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DIR   = 3'd1,
        ST_TBL   = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } walk_st_e;

    typedef enum logic [1:0] {
        FC_NONE   = 2'd0,
        FC_ABSENT = 2'd1,
        FC_PRIV   = 2'd2,
        FC_RDONLY = 2'd3
    } fault_e;

    typedef struct packed {
        logic present;
        logic writable;
        logic user_ok;
    } ent_attr_t;
endpackage

// File: rtl/ptw_entry_attr.sv
`timescale 1ns/1ps
module ptw_entry_attr
    import ptw_pkg::*;
(
    input  logic [ATTR_W-1:0] raw,
    output ent_attr_t         attr
);
    always_comb begin
        attr.present  = raw[P_BIT];
        attr.writable = raw[RW_BIT];
        attr.user_ok  = raw[US_BIT];
    end
endmodule

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
module ptw_addr_gen #(
    parameter int AW     = 32,
    parameter int DIR_W  = 10,
    parameter int TBL_W  = 10,
    parameter int ENT_SH = 2
) (
    input  logic                     use_tbl,
    input  logic [DIR_W+TBL_W-1:0]   vpn,
    input  logic [DIR_W+TBL_W-1:0]   dir_page,
    input  logic [DIR_W+TBL_W-1:0]   tbl_page,
    output logic [AW-1:0]            addr
);
    localparam int OFF_W = AW - DIR_W - TBL_W;

    logic [AW-1:0] dir_addr;
    logic [AW-1:0] tbl_addr;

    always_comb begin
        dir_addr = {dir_page, {OFF_W{1'b0}}} | (AW'(vpn[DIR_W+TBL_W-1 -: DIR_W]) << ENT_SH);
        tbl_addr = {tbl_page, {OFF_W{1'b0}}} | (AW'(vpn[TBL_W-1:0]) << ENT_SH);
        addr     = use_tbl ? tbl_addr : dir_addr;
    end
endmodule

// File: rtl/ptw_perm_check.sv
`timescale 1ns/1ps
module ptw_perm_check
    import ptw_pkg::*;
(
    input  ent_attr_t dir_attr,
    input  ent_attr_t tbl_attr,
    input  logic      is_write,
    input  logic      is_super,
    input  logic      wp_on,
    output fault_e    cause
);
    logic user_grant;
    logic write_grant;

    always_comb begin
        user_grant  = dir_attr.user_ok  & tbl_attr.user_ok;
        write_grant = dir_attr.writable & tbl_attr.writable;
        // order: absent, privilege, write
        if (!dir_attr.present || !tbl_attr.present)
            cause = FC_ABSENT;
        else if (!is_super && !user_grant)
            cause = FC_PRIV;
        else if (is_write && !write_grant && (!is_super || wp_on))
            cause = FC_RDONLY;
        else
            cause = FC_NONE;
    end
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DIR_W = 10,
    parameter int TBL_W = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [31:0]   req_lin,
    input  logic          req_write,
    input  logic          req_super,
    input  logic          pg_enable,
    input  logic          wp_enable,
    input  logic [31:0]   dir_base,
    output logic          mem_req,
    output logic [31:0]   mem_addr,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          done,
    output logic [31:0]   phys_addr,
    output logic          fault,
    output logic [1:0]    fault_cause
);
    localparam int OFF_W = AW - DIR_W - TBL_W;
    localparam int PG_W  = DIR_W + TBL_W;

    typedef struct packed {
        walk_st_e        st;
        logic [AW-1:0]   lin;
        logic            wr;
        logic            sup;
        logic            pg;
        logic            wp;
        logic [PG_W-1:0] dir_pg;
        logic [PG_W-1:0] pde_pg;
        ent_attr_t       pde_attr;
        logic [AW-1:0]   phys;
        fault_e          cause;
    } walk_t;

    walk_t q, d;

    ent_attr_t rd_attr;
    fault_e    perm_cause;
    logic      unused_bits;

    assign unused_bits = ^{mem_rdata[OFF_W-1:ATTR_W], dir_base[OFF_W-1:0]};

    ptw_entry_attr u_attr (
        .raw  (mem_rdata[ATTR_W-1:0]),
        .attr (rd_attr)
    );

    ptw_addr_gen #(
        .AW    (AW),
        .DIR_W (DIR_W),
        .TBL_W (TBL_W),
        .ENT_SH(2)
    ) u_addr (
        .use_tbl  (q.st == ST_TBL),
        .vpn      (q.lin[AW-1:OFF_W]),
        .dir_page (q.dir_pg),
        .tbl_page (q.pde_pg),
        .addr     (mem_addr)
    );

    ptw_perm_check u_perm (
        .dir_attr (q.pde_attr),
        .tbl_attr (rd_attr),
        .is_write (q.wr),
        .is_super (q.sup),
        .wp_on    (q.wp),
        .cause    (perm_cause)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.lin    = req_lin;
                    d.wr     = req_write;
                    d.sup    = req_super;
                    d.pg     = pg_enable;
                    d.wp     = wp_enable;
                    d.dir_pg = dir_base[AW-1:OFF_W];
                    d.cause  = FC_NONE;
                    if (pg_enable) begin
                        d.st = ST_DIR;
                    end else begin
                        d.st   = ST_DONE;
                        d.phys = req_lin;
                    end
                end
            end
            ST_DIR: begin
                if (mem_rvalid) begin
                    d.pde_pg   = mem_rdata[AW-1:OFF_W];
                    d.pde_attr = rd_attr;
                    if (!rd_attr.present) begin
                        d.st    = ST_FAULT;
                        d.cause = FC_ABSENT;
                    end else begin
                        d.st = ST_TBL;
                    end
                end
            end
            ST_TBL: begin
                if (mem_rvalid) begin
                    if (perm_cause != FC_NONE) begin
                        d.st    = ST_FAULT;
                        d.cause = perm_cause;
                    end else begin
                        d.st   = ST_DONE;
                        d.phys = {mem_rdata[AW-1:OFF_W], q.lin[OFF_W-1:0]};
                    end
                end
            end
            ST_DONE:  d.st = ST_IDLE;
            ST_FAULT: d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req     = (q.st == ST_DIR) || (q.st == ST_TBL);
    assign done        = (q.st == ST_DONE);
    assign fault       = (q.st == ST_FAULT);
    assign phys_addr   = q.phys;
    assign fault_cause = q.cause;

    p_bypass_noread_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> q.pg);
    p_cause_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_cause != 2'd0));
    p_priv_user_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_cause == 2'd2) |-> !q.sup);
    p_wp_super_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_cause == 2'd3 && q.sup) |-> q.wp);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_fault_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);
    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        req_super = 1'b0;
    logic        pg_enable = 1'b0;
    logic        wp_enable = 1'b0;
    logic [31:0] dir_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] phys_addr;
    logic        fault;
    logic [1:0]  fault_cause;

    int n_run = 0;
    int n_fail = 0;
    int n_rd = 0;
    int wait_cnt = 0;
    logic [31:0] rd_addr [2];
    logic [31:0] cur_pde = '0;
    logic [31:0] cur_pte = '0;

    always #5 clk = ~clk;

    ptw_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
        .req_write(req_write), .req_super(req_super), .pg_enable(pg_enable),
        .wp_enable(wp_enable), .dir_base(dir_base), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .phys_addr(phys_addr), .fault(fault), .fault_cause(fault_cause)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // memory responder: first read returns the directory entry, second the table entry
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
            end else if (mem_req && rst_n) begin
                if (wait_cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = (n_rd == 0) ? cur_pde : cur_pte;
                    if (n_rd < 2) rd_addr[n_rd] = mem_addr;
                    n_rd++;
                    wait_cnt = int'($urandom_range(0, 2));
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    task automatic walk(input logic [31:0] lin, input bit wr, input bit sup,
                        input bit pg, input bit wp, input logic [31:0] base,
                        input logic [31:0] pde, input logic [31:0] pte, input bit poke);
        bit          e_fault;
        logic [1:0]  e_cause;
        logic [31:0] e_phys;
        int          e_reads;
        bit          ug, wg;
        int          cyc;
        e_fault = 0; e_cause = 0; e_phys = '0; e_reads = 2;
        ug = pde[2] & pte[2];
        wg = pde[1] & pte[1];
        if (!pg) begin
            e_phys = lin; e_reads = 0;
        end else if (!pde[0]) begin
            e_fault = 1; e_cause = 1; e_reads = 1;
        end else if (!pte[0]) begin
            e_fault = 1; e_cause = 1;
        end else if (!sup && !ug) begin
            e_fault = 1; e_cause = 2;
        end else if (wr && !wg && (!sup || wp)) begin
            e_fault = 1; e_cause = 3;
        end else begin
            e_phys = {pte[31:12], lin[11:0]};
        end

        cur_pde = pde; cur_pte = pte; n_rd = 0;
        rd_addr[0] = '0; rd_addr[1] = '0;
        @(negedge clk);
        req_lin = lin; req_write = wr; req_super = sup; pg_enable = pg;
        wp_enable = wp; dir_base = base; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        if (poke && pg) begin
            // R11: stray strobe with different inputs while busy
            req_valid = 1'b1; req_lin = ~lin; req_write = ~wr; req_super = ~sup;
            pg_enable = 1'b0; dir_base = ~base;
        end
        while (!(done || fault) && cyc < 40) begin
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
        end
        chk(cyc < 40, "R10", "walk finished", 32'(cyc), 32'd0);
        chk(fault == e_fault && done == !e_fault, poke ? "R11" : "R4",
            "outcome fault", {31'd0, fault}, {31'd0, e_fault});
        if (e_fault) begin
            chk(fault_cause == e_cause, (e_cause == 1) ? "R5" : (e_cause == 2) ? "R6" : "R7",
                "fault cause", {30'd0, fault_cause}, {30'd0, e_cause});
        end else begin
            chk(phys_addr == e_phys, pg ? "R4" : "R1", "phys addr", phys_addr, e_phys);
        end
        chk(n_rd == e_reads, pg ? "R5" : "R1", "read count", 32'(n_rd), 32'(e_reads));
        if (!pg) chk(cyc == 1, "R1", "bypass latency", 32'(cyc), 32'd1);
        if (e_reads >= 1)
            chk(rd_addr[0] == {base[31:12], lin[31:22], 2'b00}, "R2", "dir read addr",
                rd_addr[0], {base[31:12], lin[31:22], 2'b00});
        if (e_reads == 2)
            chk(rd_addr[1] == {pde[31:12], lin[21:12], 2'b00}, "R3", "tbl read addr",
                rd_addr[1], {pde[31:12], lin[21:12], 2'b00});
        @(negedge clk);
        chk(!done && !fault, "R10", "pulse width", {30'd0, done, fault}, 32'd0);
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog all-reqs act=hung exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        chk(!done && !fault && !mem_req, "R12", "reset outputs",
            {29'd0, done, fault, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !fault && !mem_req, "R12", "idle after reset",
            {29'd0, done, fault, mem_req}, 32'd0);

        // R1 bypass
        walk(32'hDEAD_BEEF, 1, 0, 0, 1, 32'h0001_2000, 32'h0, 32'h0, 0);
        // R4 plain success
        walk(32'h1234_5678, 0, 1, 1, 0, 32'hABCD_E000, 32'h0040_0007, 32'h9876_5007, 0);
        // R5 directory absent, table absent
        walk(32'h0040_1000, 0, 1, 1, 0, 32'h0000_1000, 32'h0000_2006, 32'h0000_3007, 0);
        walk(32'h0040_1000, 0, 1, 1, 0, 32'h0000_1000, 32'h0000_2007, 32'h0000_3006, 0);
        // R6 user read of supervisor page (directory grants, table denies)
        walk(32'h8000_0ABC, 0, 0, 1, 0, 32'h0010_0000, 32'h0020_0007, 32'h0030_0003, 0);
        // R7 user write, directory read-only, table writable
        walk(32'h8000_0ABC, 1, 0, 1, 0, 32'h0010_0000, 32'h0020_0005, 32'h0030_0007, 0);
        // R8 supervisor write to read-only page: wp on faults, wp off completes
        walk(32'hC000_1111, 1, 1, 1, 1, 32'h0050_0000, 32'h0060_0005, 32'h0070_0005, 0);
        walk(32'hC000_1111, 1, 1, 1, 0, 32'h0050_0000, 32'h0060_0005, 32'h0070_0005, 0);
        // R9 priority: user write to supervisor read-only page -> privilege
        walk(32'h0BAD_F00D, 1, 0, 1, 1, 32'h0080_0000, 32'h0090_0001, 32'h00A0_0001, 0);
        // R9 priority: table absent beats privilege and write
        walk(32'h0BAD_F00D, 1, 0, 1, 1, 32'h0080_0000, 32'h0090_0001, 32'h00A0_0000, 0);
        // R11 stray request during walk
        walk(32'h5555_AAAA, 1, 0, 1, 0, 32'h00B0_0000, 32'h00C0_0007, 32'h00D0_0007, 1);

        for (int i = 0; i < 200; i++) begin
            logic [31:0] pde, pte;
            pde = $urandom;
            pte = $urandom;
            if ($urandom_range(0, 7) != 0) pde[0] = 1'b1;
            if ($urandom_range(0, 7) != 0) pte[0] = 1'b1;
            walk($urandom, 1'($urandom), 1'($urandom), $urandom_range(0, 7) != 0,
                 1'($urandom), $urandom, pde, pte, $urandom_range(0, 4) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule